// File: doc/BRIEF.md
# SoC control and status registers

This block sits on a 32-bit Wishbone-style register port and gives software three controls over the system. A reset-control word lets software fire a one-clock system-reset pulse, or hold the processor in reset for as long as a bit stays set. A scratch word resets to a fixed pattern whose bytes all differ. Software can write it, read it back and compare, to check that bus accesses work and that byte order is correct. A saturating counter records bus-timeout events reported on a pulse input by an external monitor.

The port takes a word address. Byte offset 0x0 is word 0, byte offset 0x4 is word 1, byte offset 0x8 is word 2 and byte offset 0xC is word 3. Every access is acknowledged one cycle after it is presented, whether or not the address is mapped. The system-reset pulse also returns the scratch word, the processor-hold bit and the error counter to their reset values. This holds the block in a known state while the rest of the system is reset.

Top module: `soc_ctl_regs`

## Requirements
- R1: After reset the outputs and registers are at their reset values. `sys_rst_pulse` and `cpu_hold` are 0. Word 0 reads 0x00000000. Word 1 reads 0x12345678. Word 2 reads 0.
- R2: A write to word 0 with data bit 0 set drives `sys_rst_pulse` high for exactly one cycle, the cycle in which `bus_ack` is high. Bit 0 of word 0 always reads 0.
- R3: Data bit 1 of a write to word 0 sets `cpu_hold`. It stays at that value until another write to word 0 changes it. Bit 1 of word 0 reads back the held value.
- R4: Bits 31:2 of word 0 read as zero whatever was written to them.
- R5: Word 1 is read/write. Byte-enable `bus_sel[k]` selects which byte lane of a write is stored: when set, data bits 8k+7:8k are written into the word. Lanes whose enable is clear keep their old value.
- R6: Word 2 increments by one at each clock edge where `tmo_evt` is high. Writes to word 2 do not change it.
- R7: Word 2 saturates at its all-ones value and does not wrap. The all-ones value is 0xFFFFFFFF at the default 32-bit counter width.
- R8: The clock edge that ends the system-reset pulse returns word 1 to 0x12345678, `cpu_hold` to 0 and word 2 to 0. This clear takes priority over a `tmo_evt` in the same cycle and over a hold bit written by the write that fired the pulse.
- R9: A request (`bus_cyc` and `bus_stb` high, `bus_ack` low) is acknowledged with `bus_ack` high for one cycle in the next cycle. `bus_rdat` holds the read data in that cycle.
- R10: Word 3 is unmapped. Reads of it return zero. Writes to it leave every register and output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cyc | input | 1 | Bus cycle active |
| bus_stb | input | 1 | Request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_adr | input | ADR_W | Word address |
| bus_sel | input | 4 | Byte-lane enables for writes |
| bus_wdat | input | 32 | Write data |
| bus_rdat | output | 32 | Read data, valid when `bus_ack` is high |
| bus_ack | output | 1 | Access acknowledge |
| tmo_evt | input | 1 | Bus-timeout event from the external monitor, one count per high cycle |
| sys_rst_pulse | output | 1 | One-cycle system-reset request |
| cpu_hold | output | 1 | Level-held processor reset |

## Verification
The clear carried by the system-reset pulse can fall in the same cycle as a counter increment. The bench provokes this by writing the reset-control word with both bit 0 and bit 1 set. It then raises `tmo_evt` for exactly the cycle in which the pulse is high. When the pulse ends, reads must show a counter of 0, not 1, a hold bit of 0 and a scratch word back at its reset pattern. Separately, the bench reads the counter while events keep arriving. This checks that a read returns the count from before the edge that samples it.

// File: rtl/soc_ctl_regs.sv
module soc_ctl_regs #(
  parameter int          ADR_W        = 2,
  parameter int          CNT_W        = 32,
  parameter logic [31:0] SCRATCH_INIT = 32'h1234_5678
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_cyc,
  input  logic             bus_stb,
  input  logic             bus_we,
  input  logic [ADR_W-1:0] bus_adr,
  input  logic [3:0]       bus_sel,
  input  logic [31:0]      bus_wdat,
  output logic [31:0]      bus_rdat,
  output logic             bus_ack,
  input  logic             tmo_evt,
  output logic             sys_rst_pulse,
  output logic             cpu_hold
);

  localparam logic [ADR_W-1:0] W_RST = ADR_W'(0);
  localparam logic [ADR_W-1:0] W_SCR = ADR_W'(1);
  localparam logic [ADR_W-1:0] W_ERR = ADR_W'(2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [31:0]      scratch;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      rd_mux;

  wire req = bus_cyc & bus_stb & ~bus_ack;
  wire wr  = req & bus_we;

  always_comb begin
    case (bus_adr)
      W_RST:   rd_mux = {30'd0, cpu_hold, 1'b0};
      W_SCR:   rd_mux = scratch;
      W_ERR:   rd_mux = 32'(cnt);
      default: rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack       <= 1'b0;
      bus_rdat      <= 32'd0;
      sys_rst_pulse <= 1'b0;
      cpu_hold      <= 1'b0;
    end else begin
      bus_ack       <= req;
      if (req) bus_rdat <= rd_mux;
      sys_rst_pulse <= wr && bus_adr == W_RST && bus_wdat[0];
      if (sys_rst_pulse)             cpu_hold <= 1'b0;
      else if (wr && bus_adr == W_RST) cpu_hold <= bus_wdat[1];
    end
  end

  for (genvar b = 0; b < 4; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        scratch[8*b +: 8] <= SCRATCH_INIT[8*b +: 8];
      else if (sys_rst_pulse)
        scratch[8*b +: 8] <= SCRATCH_INIT[8*b +: 8];
      else if (wr && bus_adr == W_SCR && bus_sel[b])
        scratch[8*b +: 8] <= bus_wdat[8*b +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (sys_rst_pulse)           cnt <= '0;
    else if (tmo_evt && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/soc_ctl_regs_chk.sv
module soc_ctl_regs_chk #(
  parameter int ADR_W = 2,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_cyc,
  input logic             bus_stb,
  input logic             bus_we,
  input logic [ADR_W-1:0] bus_adr,
  input logic [31:0]      bus_wdat,
  input logic [31:0]      bus_rdat,
  input logic             bus_ack,
  input logic             tmo_evt,
  input logic             sys_rst_pulse,
  input logic             cpu_hold,
  input logic [CNT_W-1:0] cnt
);
  wire req = bus_cyc && bus_stb && !bus_ack;

  AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n) req |=> bus_ack); // R9
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n) sys_rst_pulse |=> !sys_rst_pulse); // R2
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_pulse |-> $past(req && bus_we && bus_adr == '0 && bus_wdat[0])); // R2
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_pulse |=> (!cpu_hold && cnt == '0)); // R8
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_rst_pulse && tmo_evt && cnt != '1) |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R6
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_rst_pulse && !tmo_evt) |=> $stable(cnt)); // R6
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_rst_pulse && cnt == '1) |=> cnt == '1); // R7
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack && $past(!bus_we && bus_adr == '0)) |-> (bus_rdat[31:2] == '0 && !bus_rdat[0])); // R4
  AST_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack && $past(!bus_we && bus_adr > ADR_W'(2))) |-> bus_rdat == '0); // R10
endmodule

bind soc_ctl_regs soc_ctl_regs_chk #(.ADR_W(ADR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
  .bus_adr(bus_adr), .bus_wdat(bus_wdat), .bus_rdat(bus_rdat), .bus_ack(bus_ack),
  .tmo_evt(tmo_evt), .sys_rst_pulse(sys_rst_pulse), .cpu_hold(cpu_hold), .cnt(cnt)
);

// File: tb/sim_soc_ctl_regs.sv
module sim_soc_ctl_regs;
  localparam int CW = 6;
  logic clk = 0, rst_n = 0;
  logic bus_cyc = 0, bus_stb = 0, bus_we = 0, tmo_evt = 0;
  logic [1:0] bus_adr = 0;
  logic [3:0] bus_sel = 0;
  logic [31:0] bus_wdat = 0, bus_rdat;
  logic bus_ack, sys_rst_pulse, cpu_hold;
  int n_chk = 0, n_bad = 0;
  bit pulse_at_ack;

  always #10 clk = ~clk;

  soc_ctl_regs #(.ADR_W(2), .CNT_W(CW)) u0 (
    .clk, .rst_n, .bus_cyc, .bus_stb, .bus_we, .bus_adr, .bus_sel, .bus_wdat,
    .bus_rdat, .bus_ack, .tmo_evt, .sys_rst_pulse, .cpu_hold);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit we, input logic [1:0] adr, input logic [3:0] sel,
                      input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    bus_cyc = 1; bus_stb = 1; bus_we = we; bus_adr = adr; bus_sel = sel; bus_wdat = wd;
    check("R9 ack low at request", 32'(bus_ack), 0);
    @(negedge clk);
    check("R9 ack one cycle later", 32'(bus_ack), 1);
    rd = bus_rdat;
    pulse_at_ack = sys_rst_pulse;
    bus_cyc = 0; bus_stb = 0; bus_we = 0;
  endtask

  task automatic wr(input logic [1:0] adr, input logic [3:0] sel, input logic [31:0] wd);
    logic [31:0] d;
    xfer(1, adr, sel, wd, d);
  endtask

  task automatic rd(input logic [1:0] adr, output logic [31:0] d);
    xfer(0, adr, 4'h0, 32'h0, d);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    check("R1 pulse", 32'(sys_rst_pulse), 0);
    check("R1 hold", 32'(cpu_hold), 0);
    rd(0, d); check("R1 word0", d, 0);
    rd(1, d); check("R1 scratch", d, 32'h1234_5678);
    rd(2, d); check("R1 counter", d, 0);
  endtask

  task automatic t_hold_and_reserved();
    logic [31:0] d;
    wr(0, 4'hF, 32'hFFFF_FFFE);
    check("R3 hold set", 32'(cpu_hold), 1);
    check("R2 no pulse without bit0", 32'(pulse_at_ack), 0);
    rd(0, d); check("R4 reserved zero, R3 bit1 reads back", d, 32'h2);
    repeat (5) @(negedge clk);
    check("R3 hold stays", 32'(cpu_hold), 1);
    wr(0, 4'hF, 0);
    check("R3 hold released", 32'(cpu_hold), 0);
  endtask

  task automatic t_scratch_lanes();
    logic [31:0] d;
    wr(1, 4'hF, 32'hAABB_CCDD);
    rd(1, d); check("R5 full write", d, 32'hAABB_CCDD);
    wr(1, 4'b0101, 32'h1122_3344);
    rd(1, d); check("R5 lanes 0 and 2", d, 32'hAA22_CC44);
    wr(1, 4'b1000, 32'h9900_0000);
    rd(1, d); check("R5 lane 3", d, 32'h9922_CC44);
  endtask

  task automatic t_counter();
    logic [31:0] d;
    @(negedge clk); tmo_evt = 1;
    repeat (5) @(negedge clk);
    tmo_evt = 0;
    rd(2, d); check("R6 five events", d, 5);
    wr(2, 4'hF, 32'h55);
    rd(2, d); check("R6 write ignored", d, 5);
    @(negedge clk); tmo_evt = 1;
    rd(2, d); check("R6 read returns pre-edge count", d, 6);
    tmo_evt = 0;
    rd(2, d); check("R6 count during read", d, 7);
    @(negedge clk); tmo_evt = 1;
    repeat (70) @(negedge clk);
    tmo_evt = 0;
    rd(2, d); check("R7 saturated", d, 32'((1 << CW) - 1));
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    logic [31:0] scr, c;
    wr(0, 4'hF, 32'h2);
    rd(1, scr); rd(2, c);
    wr(3, 4'hF, 32'hFFFF_FFFF);
    check("R10 no pulse", 32'(pulse_at_ack), 0);
    check("R10 hold unchanged", 32'(cpu_hold), 1);
    rd(3, d); check("R10 read zero", d, 0);
    rd(1, d); check("R10 scratch unchanged", d, scr);
    rd(2, d); check("R10 counter unchanged", d, c);
    wr(0, 4'hF, 0);
  endtask

  task automatic t_pulse_clash();
    logic [31:0] d;
    wr(1, 4'hF, 32'hDEAD_BEEF);
    wr(0, 4'h0, 32'h3);
    check("R2 pulse in ack cycle", 32'(pulse_at_ack), 1);
    tmo_evt = 1;
    @(negedge clk);
    tmo_evt = 0;
    check("R2 pulse one cycle", 32'(sys_rst_pulse), 0);
    check("R8 hold cleared", 32'(cpu_hold), 0);
    rd(2, d); check("R8 counter cleared over event", d, 0);
    rd(1, d); check("R8 scratch restored", d, 32'h1234_5678);
    rd(0, d); check("R2 bit0 reads zero", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset_state();
    t_hold_and_reserved();
    t_scratch_lanes();
    t_counter();
    t_unmapped();
    t_pulse_clash();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule